// File: doc/BRIEF.md
# Synchronous Serial Shift Engine

This block is a byte-wide serial shift engine. A host reaches it through a plain parallel write/read port. On every sample edge of the shift clock, the data register moves one place towards its MSB and takes the serial input into its LSB. The same register holds the outgoing byte and the incoming byte, and there is no receive buffer behind it. Its MSB goes out through an output hold stage. The hold stage is transparent between a drive edge and the next sample edge, so the serial output changes on the edge opposite to the one that samples input.

A 4-bit edge counter advances on every sample edge and every drive edge. When it wraps after 16 edges (one byte), it sets an overflow flag. The shift clock comes either from the external clock pin or from a single-cycle timer tick. With the tick source, ticks alternate between sample and drive.

In three-wire mode the output leaves on a push-pull data-out pin. In two-wire mode the output bit instead pulls the open-drain data line low. Two-wire mode also adds:
- a start-condition detector, which sets a flag and restarts the counter;
- a clock-hold control that keeps the clock line low until the host clears the relevant flag.

All pin inputs are taken as already synchronous to `clk`, unless the `IN_SYNC` parameter inserts a register stage.

Top module: `ushift_top`

## Requirements
- R1: After reset the data register and the edge counter read 0. Both flags are 0, `do_out` is 0, and both pull outputs are 0.
- R2: A cycle with `wr_en` high loads `wr_data` into the data register, and `rd_data` returns it from the next cycle. If a sample edge falls in the same cycle, the host write wins.
- R3: A sample edge is a rising `sck_in` (pin source) or a tick in the open phase (tick source). On a sample edge the register shifts one place towards its MSB, and `di_in` enters bit 0. Input is taken from `di_in` in both wire modes.
- R4: While the hold stage is open (after reset or after a drive edge), the output bit equals the register MSB. From a sample edge until the next drive edge, it keeps the MSB that was present before that sample edge. A drive edge is a falling `sck_in` (pin source) or a tick in the closed phase.
- R5: The counter rises by 1 on every sample edge and every drive edge. It wraps from 15 to 0, and that wrap sets `ovf_flag`.
- R6: A `clr_ovf` pulse clears `ovf_flag`, and a `clr_start` pulse clears `start_flag`. When a clear coincides with a new setting event, the flag stays set.
- R7: With `src_tick` = 1, edges on `sck_in` have no effect. Each `tick` pulse alternates between a sample edge and a drive edge.
- R8: With `wire2` = 0, `do_out` carries the output bit, and `sda_pull` and `scl_pull` stay 0.
- R9: With `wire2` = 1, `do_out` is 0, and `sda_pull` is 1 exactly when the output bit is 0.
- R10: With `wire2` = 1, a fall of `di_in` while `sck_in` is high in this cycle and the previous one is a start condition. It sets `start_flag` and forces the counter to 0. With `wire2` = 0 the same stimulus does nothing.
- R11: With `wire2` = 1, `scl_pull` is 1 while `start_flag` is set. It is also 1 while `ovf_flag` is set and `hold_ovf` is 1. Clearing the flag releases the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe for the data register |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Current data register contents |
| cnt_out | output | 4 | Edge counter value |
| wire2 | input | 1 | 1 selects two-wire mode, 0 selects three-wire mode |
| src_tick | input | 1 | 1 selects the timer tick as shift clock, 0 selects the clock pin |
| hold_ovf | input | 1 | Enables clock hold while the overflow flag is set |
| tick | input | 1 | Timer compare pulse, one cycle wide |
| clr_start | input | 1 | Write-one pulse clearing the start flag |
| clr_ovf | input | 1 | Write-one pulse clearing the overflow flag |
| sck_in | input | 1 | Shift clock pin / two-wire clock line level |
| di_in | input | 1 | Serial data input / two-wire data line level |
| do_out | output | 1 | Three-wire serial data output |
| sda_pull | output | 1 | Pull data line low (two-wire) |
| scl_pull | output | 1 | Pull clock line low (two-wire) |
| start_flag | output | 1 | Start condition detected |
| ovf_flag | output | 1 | Counter overflow, byte complete |

## Verification
Some internal faults show at the ports one cycle after the edge that triggers them. A wrong phase in the hold stage makes `do_out` or `sda_pull` change on the sampling edge instead of the drive edge. A shift in the wrong direction or from the wrong input corrupts `rd_data` right after that edge. A counter that skips or repeats an edge moves `cnt_out` at once. Over a whole byte the same fault misplaces the overflow flag and the two-wire clock hold by an edge or more. A start detector that misses the clock-high qualifier, or fires in three-wire mode, shows on `start_flag` and on a counter value forced to zero in the cycle after the data line falls.

// File: rtl/ushift_pkg.sv
package ushift_pkg;
   typedef enum logic {SRC_PIN = 1'b0, SRC_TICK = 1'b1} clk_src_e;
   typedef enum logic {WIRE_THREE = 1'b0, WIRE_TWO = 1'b1} wire_mode_e;
endpackage

// File: rtl/ushift_edge_sel.sv
module ushift_edge_sel
   import ushift_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  clk_src_e src,
   input  logic     sck,
   input  logic     tick,
   output logic     sample_ev,
   output logic     drive_ev,
   output logic     open_q,
   output logic     sck_q
);
   logic primed;
   logic pin_rise, pin_fall;

   assign pin_rise = primed & sck & ~sck_q;
   assign pin_fall = primed & ~sck & sck_q;

   always_comb begin
      if (src == SRC_PIN) begin
         sample_ev = pin_rise;
         drive_ev  = pin_fall;
      end else begin
         sample_ev = tick & open_q;
         drive_ev  = tick & ~open_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         primed <= 1'b0;
         sck_q  <= 1'b0;
         open_q <= 1'b1;
      end else begin
         primed <= 1'b1;
         sck_q  <= sck;
         if (sample_ev)
            open_q <= 1'b0;
         else if (drive_ev)
            open_q <= 1'b1;
      end
   end

   // R7: without a tick the phase does not move in tick mode
   assert_tick_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_TICK && !tick) |=> $stable(open_q));
endmodule

// File: rtl/ushift_start_det.sv
module ushift_start_det (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic scl,
   input  logic scl_q,
   input  logic sda,
   output logic start_ev
);
   logic primed, sda_q;

   assign start_ev = en & primed & sda_q & ~sda & scl & scl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         primed <= 1'b0;
         sda_q  <= 1'b1;
      end else begin
         primed <= 1'b1;
         sda_q  <= sda;
      end
   end
endmodule

// File: rtl/ushift_edge_cnt.sv
module ushift_edge_cnt #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             restart,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   if (CNT_W < 2) begin : g_bad_width
      $error("ushift_edge_cnt: CNT_W must be at least 2");
   end

   assign wrap = step & ~restart & (cnt == {CNT_W{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (restart)
         cnt <= '0;
      else if (step)
         cnt <= cnt + 1'b1;
   end

   // R5: every edge advances the count by exactly one, modulo the width
   assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !restart) |=> cnt == CNT_W'($past(cnt) + 1'b1));
endmodule

// File: rtl/ushift_top.sv
module ushift_top
   import ushift_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int IN_SYNC = 0,
   localparam int CNT_W  = $clog2(2 * DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  cnt_out,
   input  logic              wire2,
   input  logic              src_tick,
   input  logic              hold_ovf,
   input  logic              tick,
   input  logic              clr_start,
   input  logic              clr_ovf,
   input  logic              sck_in,
   input  logic              di_in,
   output logic              do_out,
   output logic              sda_pull,
   output logic              scl_pull,
   output logic              start_flag,
   output logic              ovf_flag
);
   if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data_w
      $error("ushift_top: DATA_W must be a power of two, at least 2");
   end
   if (IN_SYNC != 0 && IN_SYNC != 1) begin : g_bad_sync
      $error("ushift_top: IN_SYNC must be 0 or 1");
   end

   logic sck_s, di_s;

   if (IN_SYNC == 1) begin : g_sync
      logic sck_r, di_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sck_r <= 1'b0;
            di_r  <= 1'b1;
         end else begin
            sck_r <= sck_in;
            di_r  <= di_in;
         end
      end
      assign sck_s = sck_r;
      assign di_s  = di_r;
   end else begin : g_direct
      assign sck_s = sck_in;
      assign di_s  = di_in;
   end

   wire_mode_e mode;
   clk_src_e   src;
   assign mode = wire_mode_e'(wire2);
   assign src  = clk_src_e'(src_tick);

   logic sample_ev, drive_ev, open_q, sck_q;
   logic start_ev, wrap;
   logic [DATA_W-1:0] shreg;
   logic held, do_bit;

   ushift_edge_sel u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .src      (src),
      .sck      (sck_s),
      .tick     (tick),
      .sample_ev(sample_ev),
      .drive_ev (drive_ev),
      .open_q   (open_q),
      .sck_q    (sck_q)
   );

   ushift_start_det u_start (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (mode == WIRE_TWO),
      .scl     (sck_s),
      .scl_q   (sck_q),
      .sda     (di_s),
      .start_ev(start_ev)
   );

   ushift_edge_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (sample_ev | drive_ev),
      .restart(start_ev),
      .cnt    (cnt_out),
      .wrap   (wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg      <= '0;
         held       <= 1'b0;
         ovf_flag   <= 1'b0;
         start_flag <= 1'b0;
      end else begin
         if (wr_en)
            shreg <= wr_data;
         else if (sample_ev)
            shreg <= {shreg[DATA_W-2:0], di_s};
         if (sample_ev)
            held <= shreg[DATA_W-1];
         if (wrap)
            ovf_flag <= 1'b1;
         else if (clr_ovf)
            ovf_flag <= 1'b0;
         if (start_ev)
            start_flag <= 1'b1;
         else if (clr_start)
            start_flag <= 1'b0;
      end
   end

   assign rd_data  = shreg;
   assign do_bit   = open_q ? shreg[DATA_W-1] : held;
   assign do_out   = (mode == WIRE_THREE) ? do_bit : 1'b0;
   assign sda_pull = (mode == WIRE_TWO) & ~do_bit;
   assign scl_pull = (mode == WIRE_TWO) & (start_flag | (hold_ovf & ovf_flag));

   // R4: a sample edge in the open phase leaves the output bit unchanged
   assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_ev && open_q) |=> $stable(do_bit));
   // R5: a counter wrap always raises the overflow flag
   assert_ovf_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> ovf_flag);
   // R10: a start condition flags and restarts the count
   assert_start_cnt_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> (start_flag && cnt_out == '0));
   // R11: after a start condition the clock line is held while two-wire mode stays on
   assert_scl_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> (scl_pull || !wire2));
endmodule

// File: tb/ushift_top_bench.sv
module ushift_top_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic [3:0] cnt_out;
   logic       wire2 = 1'b0, src_tick = 1'b0, hold_ovf = 1'b0, tick = 1'b0;
   logic       clr_start = 1'b0, clr_ovf = 1'b0, sck_in = 1'b0, di_in = 1'b0;
   logic       do_out, sda_pull, scl_pull, start_flag, ovf_flag;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   ushift_top u_ushift_top (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .cnt_out(cnt_out), .wire2(wire2),
      .src_tick(src_tick), .hold_ovf(hold_ovf), .tick(tick),
      .clr_start(clr_start), .clr_ovf(clr_ovf), .sck_in(sck_in),
      .di_in(di_in), .do_out(do_out), .sda_pull(sda_pull),
      .scl_pull(scl_pull), .start_flag(start_flag), .ovf_flag(ovf_flag)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic host_write(input logic [7:0] v);
      wr_data = v; wr_en = 1'b1; step(); wr_en = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 data", rd_data, 0);
      chk("R1 count", cnt_out, 0);
      chk("R1 flags", {start_flag, ovf_flag}, 0);
      chk("R1 pins", {do_out, sda_pull, scl_pull}, 0);
   endtask

   task automatic t_shift_three();
      logic [7:0] exp = 8'hA5;
      logic [7:0] inb = 8'h3C;
      host_write(8'hA5);
      chk("R2 readback", rd_data, 8'hA5);
      chk("R4 open MSB", do_out, 1);
      chk("R8 no pulls", {sda_pull, scl_pull}, 0);
      for (int i = 7; i >= 0; i--) begin
         logic [7:0] nx = {exp[6:0], inb[i]};
         di_in = inb[i]; sck_in = 1'b1; step();
         chk("R3 shift", rd_data, nx);
         chk("R4 hold old MSB", do_out, exp[7]);
         chk("R5 count rise", cnt_out, (2 * (7 - i) + 1) % 16);
         sck_in = 1'b0; step();
         chk("R4 new MSB", do_out, nx[7]);
         exp = nx;
      end
      chk("R3 byte", rd_data, 8'h3C);
      chk("R5 wrap", cnt_out, 0);
      chk("R5 ovf", ovf_flag, 1);
      clr_ovf = 1'b1; step(); clr_ovf = 1'b0;
      chk("R6 ovf clear", ovf_flag, 0);
   endtask

   task automatic t_collide();
      host_write(8'h00);
      for (int k = 0; k < 7; k++) begin
         sck_in = 1'b1; step(); sck_in = 1'b0; step();
      end
      sck_in = 1'b1; step();
      chk("R5 count 15", cnt_out, 15);
      sck_in = 1'b0; clr_ovf = 1'b1; step(); clr_ovf = 1'b0;
      chk("R6 set wins", ovf_flag, 1);
      clr_ovf = 1'b1; step(); clr_ovf = 1'b0;
      chk("R6 cleared", ovf_flag, 0);
      di_in = 1'b1; wr_data = 8'h5A; wr_en = 1'b1; sck_in = 1'b1; step();
      wr_en = 1'b0;
      chk("R2 write wins", rd_data, 8'h5A);
      chk("R5 counted", cnt_out, 1);
      sck_in = 1'b0; step();
   endtask

   task automatic t_tick();
      int c0;
      src_tick = 1'b1;
      host_write(8'h81);
      c0 = cnt_out;
      sck_in = 1'b1; step(); sck_in = 1'b0; step();
      chk("R7 pin ignored cnt", cnt_out, c0);
      chk("R7 pin ignored data", rd_data, 8'h81);
      di_in = 1'b0; tick = 1'b1; step(); tick = 1'b0;
      chk("R7 tick sample", rd_data, 8'h02);
      chk("R7 tick count", cnt_out, (c0 + 1) % 16);
      chk("R4 tick hold", do_out, 1);
      tick = 1'b1; step(); tick = 1'b0;
      chk("R7 tick drive", do_out, 0);
      chk("R7 tick count 2", cnt_out, (c0 + 2) % 16);
      src_tick = 1'b0; step();
   endtask

   task automatic t_two_wire();
      wire2 = 1'b1;
      host_write(8'h80);
      chk("R9 do low", do_out, 0);
      chk("R9 released", sda_pull, 0);
      host_write(8'h00);
      chk("R9 pulled", sda_pull, 1);
      di_in = 1'b1; step();
      sck_in = 1'b1; step();
      chk("R3 two-wire input", rd_data, 8'h01);
      chk("R5 before start", cnt_out != 0, 1);
      di_in = 1'b0; step();
      chk("R10 start flag", start_flag, 1);
      chk("R10 cnt zero", cnt_out, 0);
      chk("R11 hold on start", scl_pull, 1);
      clr_start = 1'b1; step(); clr_start = 1'b0;
      chk("R6 start clear", start_flag, 0);
      chk("R11 release", scl_pull, 0);
      hold_ovf = 1'b1;
      for (int k = 0; k < 8; k++) begin
         sck_in = 1'b0; step(); sck_in = 1'b1; step();
      end
      chk("R5 two-wire ovf", ovf_flag, 1);
      chk("R11 hold on ovf", scl_pull, 1);
      clr_ovf = 1'b1; step(); clr_ovf = 1'b0;
      chk("R11 ovf release", scl_pull, 0);
      hold_ovf = 1'b0;
      wire2 = 1'b0; di_in = 1'b1; step(); step();
      di_in = 1'b0; step();
      chk("R10 none in three-wire", start_flag, 0);
      chk("R10 cnt kept", cnt_out, 0);
      chk("R8 no pulls", {sda_pull, scl_pull}, 0);
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      step();
      t_shift_three();
      t_collide();
      t_tick();
      t_two_wire();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #200000;
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule